// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control state machine of a 16-bit load/store processor. An upstream decoder reduces each fetched word to a four-bit class code and a few flags: whether a second word follows, and whether a memory access is a store. A prefix unit supplies a repeat signal that stretches transfer states across several consecutive cycles. From these inputs the sequencer steps through one of sixteen states and drives one registered strobe per datapath action. The strobes cover instruction register load, data buffer load, PC advance, address buffer load and increment, memory read and write, pointer update, ALU writeback, register copy, immediate write, miscellaneous execute, relative jump, PC push and vector load.

ALU writeback does not get a cycle of its own. It is folded into the fetch of the following instruction, unless an interrupt is waiting. An interrupt is accepted only at an instruction boundary. Acceptance injects a hardwired call-through-stack-pointer instruction. That instruction runs the ordinary call sequence: stack pointer minus four, then two push cycles for the high half and the low half of the PC. The sequence then ends by loading the PC from the interrupt vector instead of making the relative jump. The vector is built from a base word and a vector number, with the low byte forced to zero.

Top module: `seq_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves the block in the fetch state, with only `ir_ld_o`, `pc_adv_o` and `mem_rd_o` high. Interrupt acceptance stays disabled until the first fetch after reset has ended. As a result, an ALU instruction fetched first always overlaps its writeback, even with `irq_i` high.
- R2: Every instruction starts with a fetch cycle in which `ir_ld_o`, `pc_adv_o` and `mem_rd_o` are high. The class and flags are sampled on the edge that ends this cycle. Class codes: 0 ALU, 1 register copy, 2 pointer access, 3 pointer access with pre-update, 4 pointer access with post-update, 5 direct access, 6 immediate load, 7 address arithmetic, 8 miscellaneous, 9 jump, 10 call. Codes 11 to 15 behave as 8.
- R3: When `two_word_i` is high at the end of the fetch, one cycle with `mdb_ld_o`, `pc_adv_o` and `mem_rd_o` high follows before execution.
- R4: With no interrupt being taken, an ALU instruction raises `alu_wb_o` during the next fetch cycle, together with `ir_ld_o`. When an interrupt is taken at that point, a separate cycle with only `alu_wb_o` high runs first, and then the injection cycle follows.
- R5: The register-copy state (`reg_mov_o`) and the pointer transfer state stay in place for one more cycle each time `rep_i` is high during them.
- R6: A pointer access starts with a cycle that has `mab_ld_o` high, plus `ptr_upd_o` for class 3. Transfer cycles follow, each with `mab_inc_o` high and with `mem_wr_o` high if `store_i` was high at fetch, otherwise `mem_rd_o`. Class 4 adds one final cycle with only `ptr_upd_o` high.
- R7: Direct access (memory read or write by the store flag), immediate load (`imm_wr_o`), address arithmetic (`ptr_upd_o`) and miscellaneous (`misc_ex_o`) each execute in exactly one cycle, so a single-word no-op takes two cycles.
- R8: A call runs one cycle with `mab_ld_o` and `ptr_upd_o` high, then two cycles with `pc_push_o`, `mem_wr_o` and `mab_inc_o` high. `push_lo_o` is low in the first of these (high half) and high in the second (low half). A call fetched from memory then runs one cycle of `pc_jmp_o`.
- R9: A jump instruction executes as a single `pc_jmp_o` cycle.
- R10: With `irq_i` high and acceptance enabled, the cycle after an instruction's last state is an injection cycle, with `ir_ld_o` and `ir_inject_o` high and no PC advance or memory read. The call sequence follows without its jump, and ends in one cycle with `vec_ld_o` and `irq_clr_o` high. A normal fetch comes after that.
- R11: While `vec_ld_o` is high, `vec_addr_o` equals {`vec_base_i`, `vec_num_i`, 8'h00}, taken from the inputs on the edge that starts that cycle.
- R12: `mem_rd_o` and `mem_wr_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cls_i | input | 4 | Instruction class code of the word being fetched |
| two_word_i | input | 1 | Instruction carries a second word |
| store_i | input | 1 | Memory access of the instruction is a store |
| irq_i | input | 1 | Interrupt request, held until cleared |
| rep_i | input | 1 | Repeat current transfer state for one more cycle |
| vec_base_i | input | 16 | Interrupt vector high word |
| vec_num_i | input | 8 | Interrupt vector number |
| ir_ld_o | output | 1 | Load instruction register |
| ir_inject_o | output | 1 | Instruction register takes the hardwired call word |
| mdb_ld_o | output | 1 | Load memory data buffer |
| pc_adv_o | output | 1 | Add 2 to PC |
| mab_ld_o | output | 1 | Load address buffer from address adder |
| mab_inc_o | output | 1 | Add 2 to address buffer |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| ptr_upd_o | output | 1 | Write address adder result to a memory pointer |
| alu_wb_o | output | 1 | Write ALU result to register file |
| reg_mov_o | output | 1 | Register-to-register copy |
| imm_wr_o | output | 1 | Write immediate value to register |
| misc_ex_o | output | 1 | Execute miscellaneous operation |
| pc_jmp_o | output | 1 | Load PC with PC plus offset |
| pc_push_o | output | 1 | Drive a PC half onto the store path |
| push_lo_o | output | 1 | Pushed half is the low half |
| vec_ld_o | output | 1 | Load PC from interrupt vector |
| irq_clr_o | output | 1 | Clear pending interrupt request |
| vec_addr_o | output | 32 | Composed interrupt vector address |

## Verification
The bench goes after the interplay of interrupts with the writeback overlap. A request arriving during an ALU fetch must give a separate writeback cycle before injection. A design that still overlapped would fetch a new instruction with the request pending, and one that dropped the writeback would lose a result. A request held through reset and through the first ALU fetch must not split that instruction. Requests that arrive in the middle of repeated transfers or during a call must wait for the whole sequence, including the jump. A design that checked them per state would inject mid-instruction. The two push cycles must come in high-then-low order, and an injected call must end in the vector load instead of the jump. A swapped order, a third push or a jump with the ignored offset all show up as strobe miscompares.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [3:0] {
    S_F1, S_F2, S_FI, S_ALU, S_MOV, S_MABL, S_XFER, S_POST,
    S_DIR, S_IMM, S_ADDR, S_MISC, S_JMP, S_SPDEC, S_PUSH, S_EINT
  } st_e;

  typedef enum logic [3:0] {
    C_ALU = 4'd0, C_MOV = 4'd1, C_PTR = 4'd2, C_PTR_PRE = 4'd3,
    C_PTR_POST = 4'd4, C_DIR = 4'd5, C_IMM = 4'd6, C_ADDR = 4'd7,
    C_MISC = 4'd8, C_JMP = 4'd9, C_CALL = 4'd10
  } cls_e;

  localparam int unsigned CLS_W   = 4;
  localparam int unsigned CLS_TOP = 10;

  typedef struct packed {
    cls_e cls;
    logic store;
    logic from_irq;
    logic wb_pend;
    logic push_second;
    logic irq_en;
  } ctx_t;

  typedef struct packed {
    logic ir_ld;
    logic ir_inject;
    logic mdb_ld;
    logic pc_adv;
    logic mab_ld;
    logic mab_inc;
    logic mem_rd;
    logic mem_wr;
    logic ptr_upd;
    logic alu_wb;
    logic reg_mov;
    logic imm_wr;
    logic misc_ex;
    logic pc_jmp;
    logic pc_push;
    logic push_lo;
    logic vec_ld;
    logic irq_clr;
  } ctl_t;

  localparam ctx_t CTX_RST = '{cls: C_MISC, store: 1'b0, from_irq: 1'b0,
                               wb_pend: 1'b0, push_second: 1'b0, irq_en: 1'b0};

  localparam ctl_t CTL_FETCH = '{ir_ld: 1'b1, pc_adv: 1'b1, mem_rd: 1'b1, default: 1'b0};

endpackage

// File: rtl/seq_next.sv
module seq_next
  import seq_pkg::*;
(
  input  st_e  st_q,
  input  ctx_t ctx_q,
  input  cls_e cls_in,
  input  logic two_word_i,
  input  logic store_i,
  input  logic irq_i,
  input  logic rep_i,
  output st_e  st_d,
  output ctx_t ctx_d
);

  logic take;
  st_e  done_st;

  function automatic st_e exec_of(cls_e c, logic tk);
    case (c)
      C_ALU:                         exec_of = tk ? S_ALU : S_F1;
      C_MOV:                         exec_of = S_MOV;
      C_PTR, C_PTR_PRE, C_PTR_POST:  exec_of = S_MABL;
      C_DIR:                         exec_of = S_DIR;
      C_IMM:                         exec_of = S_IMM;
      C_ADDR:                        exec_of = S_ADDR;
      C_JMP:                         exec_of = S_JMP;
      C_CALL:                        exec_of = S_SPDEC;
      default:                       exec_of = S_MISC;
    endcase
  endfunction

  always_comb begin
    take    = irq_i & ctx_q.irq_en;
    done_st = take ? S_FI : S_F1;
    st_d    = st_q;
    ctx_d   = ctx_q;
    case (st_q)
      S_F1: begin
        ctx_d.irq_en      = 1'b1;
        ctx_d.cls         = cls_in;
        ctx_d.store       = store_i;
        ctx_d.from_irq    = 1'b0;
        ctx_d.push_second = 1'b0;
        if (two_word_i) begin
          st_d          = S_F2;
          ctx_d.wb_pend = 1'b0;
        end else begin
          st_d          = exec_of(cls_in, take);
          ctx_d.wb_pend = (cls_in == C_ALU) && !take;
        end
      end
      S_F2: begin
        st_d          = exec_of(ctx_q.cls, take);
        ctx_d.wb_pend = (ctx_q.cls == C_ALU) && !take;
      end
      S_FI: begin
        ctx_d.cls         = C_CALL;
        ctx_d.from_irq    = 1'b1;
        ctx_d.push_second = 1'b0;
        ctx_d.wb_pend     = 1'b0;
        st_d              = S_SPDEC;
      end
      S_MOV:   st_d = rep_i ? S_MOV : done_st;
      S_MABL:  st_d = S_XFER;
      S_XFER: begin
        if (rep_i)                          st_d = S_XFER;
        else if (ctx_q.cls == C_PTR_POST)   st_d = S_POST;
        else                                st_d = done_st;
      end
      S_SPDEC: begin
        ctx_d.push_second = 1'b0;
        st_d              = S_PUSH;
      end
      S_PUSH: begin
        if (!ctx_q.push_second) begin
          ctx_d.push_second = 1'b1;
          st_d              = S_PUSH;
        end else begin
          st_d = ctx_q.from_irq ? S_EINT : S_JMP;
        end
      end
      S_EINT: begin
        ctx_d.from_irq = 1'b0;
        st_d           = S_F1;
      end
      default: st_d = done_st;
    endcase
  end

endmodule

// File: rtl/seq_strobe.sv
module seq_strobe
  import seq_pkg::*;
(
  input  st_e  st,
  input  logic wb_pend,
  input  logic store,
  input  logic pre,
  input  logic second,
  output ctl_t ctl
);

  always_comb begin
    ctl = '0;
    case (st)
      S_F1: begin
        ctl.ir_ld  = 1'b1;
        ctl.pc_adv = 1'b1;
        ctl.mem_rd = 1'b1;
        ctl.alu_wb = wb_pend;
      end
      S_F2: begin
        ctl.mdb_ld = 1'b1;
        ctl.pc_adv = 1'b1;
        ctl.mem_rd = 1'b1;
      end
      S_FI: begin
        ctl.ir_ld     = 1'b1;
        ctl.ir_inject = 1'b1;
      end
      S_ALU:  ctl.alu_wb  = 1'b1;
      S_MOV:  ctl.reg_mov = 1'b1;
      S_MABL: begin
        ctl.mab_ld  = 1'b1;
        ctl.ptr_upd = pre;
      end
      S_XFER: begin
        ctl.mab_inc = 1'b1;
        ctl.mem_rd  = !store;
        ctl.mem_wr  = store;
      end
      S_POST: ctl.ptr_upd = 1'b1;
      S_DIR: begin
        ctl.mem_rd = !store;
        ctl.mem_wr = store;
      end
      S_IMM:  ctl.imm_wr  = 1'b1;
      S_ADDR: ctl.ptr_upd = 1'b1;
      S_MISC: ctl.misc_ex = 1'b1;
      S_JMP:  ctl.pc_jmp  = 1'b1;
      S_SPDEC: begin
        ctl.mab_ld  = 1'b1;
        ctl.ptr_upd = 1'b1;
      end
      S_PUSH: begin
        ctl.pc_push = 1'b1;
        ctl.mem_wr  = 1'b1;
        ctl.mab_inc = 1'b1;
        ctl.push_lo = second;
      end
      S_EINT: begin
        ctl.vec_ld  = 1'b1;
        ctl.irq_clr = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/seq_vec.sv
module seq_vec #(
  parameter int unsigned BASE_W = 16,
  parameter int unsigned NUM_W  = 8,
  parameter int unsigned PAD_W  = 8,
  localparam int unsigned ADDR_W = BASE_W + NUM_W + PAD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BASE_W-1:0] base,
  input  logic [NUM_W-1:0]  num,
  output logic [ADDR_W-1:0] addr
);

  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= {base, num, {PAD_W{1'b0}}};
  end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int unsigned VEC_BASE_W = 16,
  parameter int unsigned VEC_NUM_W  = 8,
  parameter int unsigned VEC_PAD_W  = 8
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic [CLS_W-1:0]                        cls_i,
  input  logic                                    two_word_i,
  input  logic                                    store_i,
  input  logic                                    irq_i,
  input  logic                                    rep_i,
  input  logic [VEC_BASE_W-1:0]                   vec_base_i,
  input  logic [VEC_NUM_W-1:0]                    vec_num_i,
  output logic                                    ir_ld_o,
  output logic                                    ir_inject_o,
  output logic                                    mdb_ld_o,
  output logic                                    pc_adv_o,
  output logic                                    mab_ld_o,
  output logic                                    mab_inc_o,
  output logic                                    mem_rd_o,
  output logic                                    mem_wr_o,
  output logic                                    ptr_upd_o,
  output logic                                    alu_wb_o,
  output logic                                    reg_mov_o,
  output logic                                    imm_wr_o,
  output logic                                    misc_ex_o,
  output logic                                    pc_jmp_o,
  output logic                                    pc_push_o,
  output logic                                    push_lo_o,
  output logic                                    vec_ld_o,
  output logic                                    irq_clr_o,
  output logic [VEC_BASE_W+VEC_NUM_W+VEC_PAD_W-1:0] vec_addr_o
);

  st_e  st_q, st_d;
  ctx_t ctx_q, ctx_d;
  ctl_t ctl_q, ctl_d;
  cls_e cls_n;

  always_comb begin
    if (cls_i <= CLS_W'(CLS_TOP)) cls_n = cls_e'(cls_i);
    else                          cls_n = C_MISC;
  end

  seq_next u_next (
    .st_q       (st_q),
    .ctx_q      (ctx_q),
    .cls_in     (cls_n),
    .two_word_i (two_word_i),
    .store_i    (store_i),
    .irq_i      (irq_i),
    .rep_i      (rep_i),
    .st_d       (st_d),
    .ctx_d      (ctx_d)
  );

  seq_strobe u_strobe (
    .st      (st_d),
    .wb_pend (ctx_d.wb_pend),
    .store   (ctx_d.store),
    .pre     (ctx_d.cls == C_PTR_PRE),
    .second  (ctx_d.push_second),
    .ctl     (ctl_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= S_F1;
      ctx_q <= CTX_RST;
      ctl_q <= CTL_FETCH;
    end else begin
      st_q  <= st_d;
      ctx_q <= ctx_d;
      ctl_q <= ctl_d;
    end
  end

  seq_vec #(
    .BASE_W (VEC_BASE_W),
    .NUM_W  (VEC_NUM_W),
    .PAD_W  (VEC_PAD_W)
  ) u_vec (
    .clk  (clk),
    .rst  (rst),
    .load (st_d == S_EINT),
    .base (vec_base_i),
    .num  (vec_num_i),
    .addr (vec_addr_o)
  );

  assign ir_ld_o     = ctl_q.ir_ld;
  assign ir_inject_o = ctl_q.ir_inject;
  assign mdb_ld_o    = ctl_q.mdb_ld;
  assign pc_adv_o    = ctl_q.pc_adv;
  assign mab_ld_o    = ctl_q.mab_ld;
  assign mab_inc_o   = ctl_q.mab_inc;
  assign mem_rd_o    = ctl_q.mem_rd;
  assign mem_wr_o    = ctl_q.mem_wr;
  assign ptr_upd_o   = ctl_q.ptr_upd;
  assign alu_wb_o    = ctl_q.alu_wb;
  assign reg_mov_o   = ctl_q.reg_mov;
  assign imm_wr_o    = ctl_q.imm_wr;
  assign misc_ex_o   = ctl_q.misc_ex;
  assign pc_jmp_o    = ctl_q.pc_jmp;
  assign pc_push_o   = ctl_q.pc_push;
  assign push_lo_o   = ctl_q.push_lo;
  assign vec_ld_o    = ctl_q.vec_ld;
  assign irq_clr_o   = ctl_q.irq_clr;

endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
  parameter int unsigned BASE_W = 16,
  parameter int unsigned NUM_W  = 8,
  parameter int unsigned PAD_W  = 8
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          ir_ld,
  input logic                          ir_inject,
  input logic                          mdb_ld,
  input logic                          mab_ld,
  input logic                          ptr_upd,
  input logic                          mem_rd,
  input logic                          mem_wr,
  input logic                          pc_push,
  input logic                          push_lo,
  input logic                          pc_jmp,
  input logic                          vec_ld,
  input logic [BASE_W+NUM_W+PAD_W-1:0] vec_addr,
  input logic [BASE_W-1:0]             vec_base,
  input logic [NUM_W-1:0]              vec_num
);

  p_mem_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  p_mdb_after_fetch_r3: assert property (@(posedge clk) disable iff (rst)
    mdb_ld |-> $past(ir_ld && !ir_inject));

  p_inject_then_spdec_r10: assert property (@(posedge clk) disable iff (rst)
    ir_inject |=> (mab_ld && ptr_upd));

  p_vec_then_fetch_r10: assert property (@(posedge clk) disable iff (rst)
    vec_ld |=> (ir_ld && !ir_inject));

  p_push_pair_r8: assert property (@(posedge clk) disable iff (rst)
    (pc_push && !push_lo) |=> (pc_push && push_lo));

  p_push_end_r8: assert property (@(posedge clk) disable iff (rst)
    (pc_push && push_lo) |=> (pc_jmp || vec_ld));

  p_vec_fmt_r11: assert property (@(posedge clk) disable iff (rst)
    vec_ld |-> ((vec_addr[PAD_W-1:0] == '0)
             && (vec_addr[PAD_W +: NUM_W] == $past(vec_num))
             && (vec_addr[PAD_W+NUM_W +: BASE_W] == $past(vec_base))));

endmodule

bind seq_ctrl seq_chk #(
  .BASE_W (VEC_BASE_W),
  .NUM_W  (VEC_NUM_W),
  .PAD_W  (VEC_PAD_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ir_ld     (ir_ld_o),
  .ir_inject (ir_inject_o),
  .mdb_ld    (mdb_ld_o),
  .mab_ld    (mab_ld_o),
  .ptr_upd   (ptr_upd_o),
  .mem_rd    (mem_rd_o),
  .mem_wr    (mem_wr_o),
  .pc_push   (pc_push_o),
  .push_lo   (push_lo_o),
  .pc_jmp    (pc_jmp_o),
  .vec_ld    (vec_ld_o),
  .vec_addr  (vec_addr_o),
  .vec_base  (vec_base_i),
  .vec_num   (vec_num_i)
);

// File: tb/test_seq_ctrl.sv
module test_seq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NPROG      = 400;
  localparam int LIMIT      = 20000;

  localparam int Q_F1 = 0, Q_F2 = 1, Q_FI = 2, Q_ALU = 3, Q_MOV = 4, Q_MABL = 5,
                 Q_XFER = 6, Q_POST = 7, Q_DIR = 8, Q_IMM = 9, Q_ADDR = 10,
                 Q_MISC = 11, Q_JMP = 12, Q_SPDEC = 13, Q_PUSH = 14, Q_EINT = 15;

  logic clk = 1'b0;
  logic rst, two_r, store_r, irq_r, rep_r;
  logic [3:0] cls_r;
  logic [15:0] base_r;
  logic [7:0] num_r;
  logic ir_ld, ir_inj, mdb_ld, pc_adv, mab_ld, mab_inc, mem_rd, mem_wr, ptr_upd;
  logic alu_wb, reg_mov, imm_wr, misc_ex, pc_jmp, pc_push, push_lo, vec_ld, irq_clr;
  logic [31:0] vec_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_ctrl i_seq_ctrl (
    .clk(clk), .rst(rst), .cls_i(cls_r), .two_word_i(two_r), .store_i(store_r),
    .irq_i(irq_r), .rep_i(rep_r), .vec_base_i(base_r), .vec_num_i(num_r),
    .ir_ld_o(ir_ld), .ir_inject_o(ir_inj), .mdb_ld_o(mdb_ld), .pc_adv_o(pc_adv),
    .mab_ld_o(mab_ld), .mab_inc_o(mab_inc), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .ptr_upd_o(ptr_upd), .alu_wb_o(alu_wb), .reg_mov_o(reg_mov), .imm_wr_o(imm_wr),
    .misc_ex_o(misc_ex), .pc_jmp_o(pc_jmp), .pc_push_o(pc_push), .push_lo_o(push_lo),
    .vec_ld_o(vec_ld), .irq_clr_o(irq_clr), .vec_addr_o(vec_addr)
  );

  int vectors = 0;
  int fails   = 0;

  int p_cls[NPROG], p_two[NPROG], p_st[NPROG], p_rep[NPROG], p_irq[NPROG];
  int nprog = 0;

  task automatic add(int c, int t, int s, int r, int q);
    p_cls[nprog] = c; p_two[nprog] = t; p_st[nprog] = s;
    p_rep[nprog] = r; p_irq[nprog] = q; nprog++;
  endtask

  task automatic chk(string tag, string nm, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_st, m_cls;
  bit m_store, m_int, m_wb, m_sec, m_en;
  logic [31:0] m_vec;

  function automatic int first_exec(int c, bit tk);
    if (c == 0) return tk ? Q_ALU : Q_F1;
    if (c == 1) return Q_MOV;
    if (c >= 2 && c <= 4) return Q_MABL;
    if (c == 5) return Q_DIR;
    if (c == 6) return Q_IMM;
    if (c == 7) return Q_ADDR;
    if (c == 9) return Q_JMP;
    if (c == 10) return Q_SPDEC;
    return Q_MISC;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = Q_F1; m_cls = 8; m_store = 0; m_int = 0; m_wb = 0; m_sec = 0; m_en = 0; m_vec = '0;
    end else begin
      bit tk;
      int fin;
      int nc;
      tk  = irq_r && m_en;
      fin = tk ? Q_FI : Q_F1;
      nc  = (int'(cls_r) > 10) ? 8 : int'(cls_r);
      case (m_st)
        Q_F1: begin
          m_en = 1; m_cls = nc; m_store = store_r; m_int = 0; m_sec = 0;
          if (two_r) begin m_st = Q_F2; m_wb = 0; end
          else begin m_wb = (nc == 0) && !tk; m_st = first_exec(nc, tk); end
        end
        Q_F2: begin m_wb = (m_cls == 0) && !tk; m_st = first_exec(m_cls, tk); end
        Q_FI: begin m_cls = 10; m_int = 1; m_wb = 0; m_sec = 0; m_st = Q_SPDEC; end
        Q_MOV: m_st = rep_r ? Q_MOV : fin;
        Q_MABL: m_st = Q_XFER;
        Q_XFER: m_st = rep_r ? Q_XFER : ((m_cls == 4) ? Q_POST : fin);
        Q_SPDEC: begin m_sec = 0; m_st = Q_PUSH; end
        Q_PUSH: begin
          if (!m_sec) m_sec = 1;
          else m_st = m_int ? Q_EINT : Q_JMP;
        end
        Q_EINT: begin m_int = 0; m_st = Q_F1; end
        default: m_st = fin;
      endcase
      if (m_st == Q_EINT) m_vec = {base_r, num_r, 8'h00};
    end
  end

  task automatic compare_all();
    bit xr, xw;
    xr = (m_st == Q_F1) || (m_st == Q_F2) || (((m_st == Q_XFER) || (m_st == Q_DIR)) && !m_store);
    xw = (((m_st == Q_XFER) || (m_st == Q_DIR)) && m_store) || (m_st == Q_PUSH);
    chk("R2",  "ir_ld",   32'(ir_ld),   32'((m_st == Q_F1) || (m_st == Q_FI)));
    chk("R2",  "pc_adv",  32'(pc_adv),  32'((m_st == Q_F1) || (m_st == Q_F2)));
    chk("R2",  "mem_rd",  32'(mem_rd),  32'(xr));
    chk("R3",  "mdb_ld",  32'(mdb_ld),  32'(m_st == Q_F2));
    chk("R4",  "alu_wb",  32'(alu_wb),  32'(((m_st == Q_F1) && m_wb) || (m_st == Q_ALU)));
    chk("R5",  "reg_mov", 32'(reg_mov), 32'(m_st == Q_MOV));
    chk("R6",  "mab_ld",  32'(mab_ld),  32'((m_st == Q_MABL) || (m_st == Q_SPDEC)));
    chk("R6",  "mab_inc", 32'(mab_inc), 32'((m_st == Q_XFER) || (m_st == Q_PUSH)));
    chk("R6",  "mem_wr",  32'(mem_wr),  32'(xw));
    chk("R6",  "ptr_upd", 32'(ptr_upd), 32'(((m_st == Q_MABL) && (m_cls == 3)) || (m_st == Q_POST)
                                             || (m_st == Q_ADDR) || (m_st == Q_SPDEC)));
    chk("R7",  "imm_wr",  32'(imm_wr),  32'(m_st == Q_IMM));
    chk("R7",  "misc_ex", 32'(misc_ex), 32'(m_st == Q_MISC));
    chk("R8",  "pc_push", 32'(pc_push), 32'(m_st == Q_PUSH));
    chk("R8",  "push_lo", 32'(push_lo), 32'((m_st == Q_PUSH) && m_sec));
    chk("R9",  "pc_jmp",  32'(pc_jmp),  32'(m_st == Q_JMP));
    chk("R10", "ir_inject", 32'(ir_inj), 32'(m_st == Q_FI));
    chk("R10", "vec_ld",  32'(vec_ld),  32'(m_st == Q_EINT));
    chk("R10", "irq_clr", 32'(irq_clr), 32'(m_st == Q_EINT));
    chk("R11", "vec_addr", vec_addr, m_vec);
    chk("R12", "rd_wr_excl", 32'(mem_rd && mem_wr), 32'(0));
  endtask

  int idx = 0;
  int rep_left = 0;

  task automatic drive_next();
    if (idx < nprog) begin
      cls_r   = 4'(p_cls[idx]);
      two_r   = p_two[idx][0];
      store_r = p_st[idx][0];
      rep_left = p_rep[idx];
      if (p_irq[idx] != 0) irq_r = 1'b1;
      idx++;
    end else begin
      cls_r = 4'd8; two_r = 1'b0; store_r = 1'b0; rep_left = 0;
    end
  endtask

  initial begin
    int cyc;
    int tail;
    void'($urandom(29));
    // directed program: class, two-word, store, repeats, raise irq
    add(0, 0, 0, 0, 0);   // ALU first, irq held from reset (R1)
    add(8, 0, 0, 0, 0);   // no-op, then injection (R7, R10)
    add(1, 0, 0, 2, 0);   // copy, 2 repeats (R5)
    add(2, 0, 0, 0, 0);   // pointer load (R6)
    add(3, 0, 1, 1, 0);   // pre-update store, 1 repeat (R6)
    add(4, 0, 0, 0, 0);   // post-update load (R6)
    add(5, 1, 1, 0, 0);   // direct store, two-word (R3, R7)
    add(6, 1, 0, 0, 0);   // immediate (R7)
    add(7, 0, 0, 0, 0);   // address arithmetic (R7)
    add(9, 1, 0, 0, 0);   // jump (R9)
    add(10, 0, 0, 0, 0);  // call (R8)
    add(0, 0, 0, 0, 1);   // ALU with irq: separate writeback (R4)
    add(0, 1, 0, 0, 1);   // two-word ALU with irq (R4)
    add(13, 0, 0, 0, 0);  // unused code acts as misc (R2)
    add(1, 0, 0, 3, 1);   // irq during repeats (R5, R10)
    add(10, 1, 0, 0, 1);  // irq during call waits for jump (R8, R10)
    add(0, 0, 0, 0, 0);
    add(0, 0, 0, 0, 0);   // back-to-back overlap (R4)
    add(4, 0, 1, 2, 1);
    while (nprog < NPROG)
      add(int'($urandom_range(0, 15)), int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
          int'($urandom_range(0, 3)), ($urandom_range(0, 7) == 0) ? 1 : 0);

    rst = 1'b1; irq_r = 1'b1; rep_r = 1'b0; base_r = 16'hA5C3; num_r = 8'h3B;
    drive_next();
    @(negedge clk);
    @(negedge clk);
    // R1: reset state is the fetch cycle only
    chk("R1", "reset_ir_ld",  32'(ir_ld),  32'(1));
    chk("R1", "reset_pc_adv", 32'(pc_adv), 32'(1));
    chk("R1", "reset_mem_rd", 32'(mem_rd), 32'(1));
    chk("R1", "reset_others", 32'({mdb_ld, mab_ld, mab_inc, mem_wr, ptr_upd, alu_wb, reg_mov,
                                    imm_wr, misc_ex, pc_jmp, pc_push, ir_inj, vec_ld, irq_clr}), 32'(0));
    compare_all();
    rst = 1'b0;
    cyc = 0; tail = 0;
    while ((idx < nprog || tail < 40) && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      compare_all();
      if (cyc == 1) begin
        // R1: first ALU overlaps its writeback despite irq held through reset
        chk("R1", "first_overlap", 32'({ir_ld, alu_wb, ir_inj}), 32'(3'b110));
      end
      if (m_st == 5 - 1 + 1 - 1 + 0 && 0) rep_r = 1'b0;
      if (m_st == Q_EINT) irq_r = 1'b0;
      if ((m_st == Q_MOV) || (m_st == Q_XFER)) begin
        rep_r = (rep_left > 0);
        if (rep_left > 0) rep_left--;
      end else begin
        rep_r = 1'b0;
      end
      if (m_st == Q_F1) begin
        base_r = base_r + 16'h0101;
        num_r  = num_r + 8'h07;
        drive_next();
      end
      if (idx >= nprog) tail++;
    end
    if (cyc >= LIMIT) begin
      fails++;
      vectors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, LIMIT);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule